// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte path of an Ethernet-style MAC. It watches the first six bytes of every incoming frame, which hold the destination address, and returns one accept or reject verdict per frame. Address type sets which rule applies. Unicast addresses are compared with a programmed 48-bit station address. The all-ones address is handled as broadcast. Multicast addresses are either all accepted or tested against a 64-bit hash table. The table is indexed by six bits of a CRC-32 that the block computes over the address as the bytes arrive.

The stream is qualified byte by byte with a valid strobe. A frame-start strobe marks the first address byte. Idle cycles may occur between address bytes. The verdict appears shortly after the sixth byte and stays unchanged until the next frame starts. Bytes after the address (payload and FCS) do not affect it. Storing frames and programming the table are handled elsewhere.

Top module: `da_filter`

## Requirements
- R1: With the promiscuous bit low, a unicast frame is accepted when all 48 address bits equal `station_addr` and rejected otherwise. Unicast means bit 0 of the first address byte is 0. The first byte received is compared with `station_addr[47:40]`, and the last byte with `station_addr[7:0]`.
- R2: With the promiscuous bit high, every unicast frame is accepted whatever its address.
- R3: A multicast frame has bit 0 of its first address byte set and is not all ones. Such a frame is always accepted while `mcast_all` is high.
- R4: The hash index is bits 28 down to 23 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, starts at 0xFFFFFFFF and is neither reflected nor inverted at the end. Bytes are fed in arrival order, each least significant bit first. With `hash_en` high, a multicast frame is accepted when its table bit is 1.
- R5: Index values 0 to 31 select `hash_lo[index]`. Values 32 to 63 select `hash_hi[index-32]`.
- R6: A multicast frame is rejected when `mcast_all` is low and either `hash_en` is low or the selected table bit is 0. The promiscuous bit has no effect on multicast frames.
- R7: The all-ones address is accepted exactly when `bcast_en` is high, whatever the other mode bits and the table hold.
- R8: Take edge E as the clock edge that samples the sixth address byte. `verdict_valid` is still low just after E and goes high at edge E+1, with `accept` valid from that edge.
- R9: `verdict_valid` and `accept` hold their values until an edge samples a new frame start. That edge clears both.
- R10: Bytes that arrive after the sixth address byte and before the next frame start have no effect on the verdict. Idle cycles between address bytes are allowed.
- R11: After reset, `verdict_valid` and `accept` are 0. Bytes that arrive without a preceding frame start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Marks the byte on `rx_data` as the first byte of a frame (used only with `rx_valid`) |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address; bits 47:40 hold the first byte on the line |
| hash_lo | input | 32 | Hash table entries 0 to 31 |
| hash_hi | input | 32 | Hash table entries 32 to 63 |
| promisc | input | 1 | Accept every unicast frame |
| mcast_all | input | 1 | Accept every multicast frame |
| hash_en | input | 1 | Accept multicast frames whose table bit is set |
| bcast_en | input | 1 | Accept broadcast frames |
| verdict_valid | output | 1 | `accept` holds the verdict for the current frame |
| accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
Each verdict passes through two registers: the address capture stage and the verdict stage. The verdict is therefore due one edge after the edge that samples the sixth byte. The bench drives inputs on falling edges. At the falling edge right after the sixth byte is sampled, it checks that `verdict_valid` is still low. One full cycle later, it checks `verdict_valid` and `accept` against a verdict computed from the requirements, including a bench-side bit-serial CRC for the hash index. A new frame start is checked for its clear at the falling edge right after the start byte is sampled. Trailing bytes are checked by sampling the held verdict after each one.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic promisc;
        logic mcast_all;
        logic hash_en;
        logic bcast_en;
    } mode_t;

    // Advance the CRC register by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                       input logic [7:0]       b);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            fb = c[CRC_W-1] ^ b[k];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_MSB   = 28,
    parameter int HASH_LSB   = 23,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1),
    localparam int IDX_W     = HASH_MSB - HASH_LSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  hash_idx_o,
    output logic              done_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
        logic              done;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = 1'b0;
        if (start_i) begin
            cap_d.cnt  = CNT_W'(1);
            cap_d.addr = {{(ADDR_W-8){1'b0}}, byte_i};
            cap_d.crc  = crc_step_byte(CRC_INIT, byte_i);
            cap_d.done = (ADDR_BYTES == 1);
        end else if (byte_valid_i && (cap_q.cnt < CNT_FULL)) begin
            cap_d.cnt  = cap_q.cnt + CNT_W'(1);
            cap_d.addr = {cap_q.addr[ADDR_W-9:0], byte_i};
            cap_d.crc  = crc_step_byte(cap_q.crc, byte_i);
            cap_d.done = (cap_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.cnt  <= CNT_FULL;   // idle: wait for a frame start
            cap_q.addr <= '0;
            cap_q.crc  <= CRC_INIT;
            cap_q.done <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_o     = cap_q.addr;
    assign hash_idx_o = cap_q.crc[HASH_MSB:HASH_LSB];
    assign done_o     = cap_q.done;

    // R10: once the address is complete, later bytes leave it untouched
    a_r10_tail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_q.cnt == CNT_FULL) && !start_i) |=> $stable(addr_o));

    // R8: completion is a single-cycle pulse per frame
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6,
    localparam int TBL_W = 1 << IDX_W,
    localparam int HALF_W = TBL_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  hash_idx_i,
    input  logic [ADDR_W-1:0] station_i,
    input  logic [HALF_W-1:0] tbl_lo_i,
    input  logic [HALF_W-1:0] tbl_hi_i,
    input  mode_t             mode_i,
    output logic              valid_o,
    output logic              accept_o
);

    typedef struct packed {
        logic valid;
        logic accept;
    } ver_s;

    ver_s ver_d, ver_q;

    logic [TBL_W-1:0] table_w;
    logic             is_bcast, is_mcast, tbl_hit, verdict;

    always_comb begin
        table_w  = {tbl_hi_i, tbl_lo_i};
        is_bcast = &addr_i;
        is_mcast = addr_i[ADDR_W-8];          // group bit of the first byte
        tbl_hit  = table_w[hash_idx_i];
        if (is_bcast)
            verdict = mode_i.bcast_en;
        else if (is_mcast)
            verdict = mode_i.mcast_all | (mode_i.hash_en & tbl_hit);
        else
            verdict = mode_i.promisc | (addr_i == station_i);
    end

    always_comb begin
        ver_d = ver_q;
        if (start_i) begin
            ver_d.valid  = 1'b0;
            ver_d.accept = 1'b0;
        end else if (done_i) begin
            ver_d.valid  = 1'b1;
            ver_d.accept = verdict;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ver_q <= '0;
        else        ver_q <= ver_d;
    end

    assign valid_o  = ver_q.valid;
    assign accept_o = ver_q.accept;

    a_r8_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> valid_o);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!valid_o && !accept_o));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> (valid_o && $stable(accept_o)));

    a_r1_station_match: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i && !addr_i[ADDR_W-8] && (addr_i == station_i)) |=> accept_o);

    a_r7_bcast_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i && (&addr_i)) |=> (accept_o == $past(mode_i.bcast_en)));

endmodule

// File: rtl/da_filter.sv
module da_filter
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_MSB   = 28,
    parameter int HASH_LSB   = 23,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int IDX_W     = HASH_MSB - HASH_LSB + 1,
    localparam int HALF_W    = (1 << IDX_W) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [HALF_W-1:0] hash_lo,
    input  logic [HALF_W-1:0] hash_hi,
    input  logic              promisc,
    input  logic              mcast_all,
    input  logic              hash_en,
    input  logic              bcast_en,
    output logic              verdict_valid,
    output logic              accept
);

    logic              start_w, done_w;
    logic [ADDR_W-1:0] addr_w;
    logic [IDX_W-1:0]  idx_w;
    mode_t             mode_w;

    assign start_w = rx_sof & rx_valid;
    assign mode_w  = '{promisc: promisc, mcast_all: mcast_all,
                       hash_en: hash_en, bcast_en: bcast_en};

    dafilt_capture #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_MSB   (HASH_MSB),
        .HASH_LSB   (HASH_LSB)
    ) i_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .byte_valid_i (rx_valid),
        .byte_i       (rx_data),
        .addr_o       (addr_w),
        .hash_idx_o   (idx_w),
        .done_o       (done_w)
    );

    dafilt_decide #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) i_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .done_i     (done_w),
        .addr_i     (addr_w),
        .hash_idx_i (idx_w),
        .station_i  (station_addr),
        .tbl_lo_i   (hash_lo),
        .tbl_hi_i   (hash_hi),
        .mode_i     (mode_w),
        .valid_o    (verdict_valid),
        .accept_o   (accept)
    );

    // R11: nothing is reported until a frame has started
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!verdict_valid && !done_w) |=> !verdict_valid);

endmodule

// File: tb/test_da_filter.sv
module test_da_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic        promisc = 0, mcast_all = 0, hash_en = 0, bcast_en = 0;
    logic        verdict_valid, accept;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    da_filter i_da_filter (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .station_addr(station_addr), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .promisc(promisc), .mcast_all(mcast_all), .hash_en(hash_en), .bcast_en(bcast_en),
        .verdict_valid(verdict_valid), .accept(accept)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Bit-serial reference of the hash index (R4)
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic bit_in = a[40 - 8*i + j];
                logic top = r[31];
                r = r << 1;
                if (top ^ bit_in) r = r ^ 32'h04C11DB7;
            end
        end
        return r[28:23];
    endfunction

    // Send a 6-byte address with optional idle cycles, check R8 timing and the verdict
    task automatic send_addr(input logic [47:0] a, input int gap, input logic exp, input string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_sof = (i == 0); rx_valid = 1'b1; rx_data = a[47 - 8*i -: 8];
            if (i == 0) begin
                @(negedge clk);   // start byte sampled: verdict cleared (R9)
                chk("R9 start clears valid", verdict_valid, 1'b0);
                rx_sof = 1'b0; rx_valid = 1'b0;
                if (gap == 0) begin
                    rx_valid = 1'b1; rx_data = a[39:32];
                    i = 1;
                end
            end
            if (gap > 0 && i < 5 && i > 0) begin
                @(negedge clk); rx_sof = 1'b0; rx_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk("R8 not valid just after sixth byte", verdict_valid, 1'b0);
        @(negedge clk);
        chk("R8 valid one edge later", verdict_valid, 1'b1);
        chk(req, accept, exp);
    endtask

    task automatic t_reset();
        chk("R11 reset valid", verdict_valid, 1'b0);
        chk("R11 reset accept", accept, 1'b0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'(k);
        end
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
        chk("R11 bytes without start ignored", verdict_valid, 1'b0);
    endtask

    task automatic t_unicast();
        promisc = 0;
        send_addr(station_addr, 0, 1'b1, "R1 unicast match");
        send_addr(48'h02_11_22_33_44_54, 0, 1'b0, "R1 unicast mismatch last byte");
        send_addr(48'h03_11_22_33_44_55 ^ 48'h01_00_00_00_00_00 ^ 48'h80_00_00_00_00_00, 0, 1'b0,
                  "R1 unicast mismatch first byte");
        promisc = 1;
        send_addr(48'h0A_BB_CC_DD_EE_FF, 0, 1'b1, "R2 promiscuous unicast");
        promisc = 0;
    endtask

    task automatic t_bcast();
        bcast_en = 1;
        send_addr(48'hFFFF_FFFF_FFFF, 0, 1'b1, "R7 broadcast enabled");
        bcast_en = 0; promisc = 1; mcast_all = 1; hash_en = 1; hash_lo = '1; hash_hi = '1;
        send_addr(48'hFFFF_FFFF_FFFF, 0, 1'b0, "R7 broadcast disabled");
        promisc = 0; mcast_all = 0; hash_en = 0; hash_lo = '0; hash_hi = '0;
    endtask

    task automatic t_mcast_all();
        mcast_all = 1;
        send_addr(48'h01_00_5E_7F_00_01, 0, 1'b1, "R3 accept all multicast");
        mcast_all = 0; promisc = 1;
        send_addr(48'h01_00_5E_7F_00_01, 0, 1'b0, "R6 promiscuous has no multicast effect");
        promisc = 0;
    endtask

    task automatic t_hash();
        logic [47:0] a_lo = '0, a_hi = '0;
        logic [5:0]  i_lo = '0, i_hi = '0;
        bit got_lo = 0, got_hi = 0;
        for (int k = 0; k < 256; k++) begin
            logic [47:0] a = 48'h01_00_5E_00_00_00 | 48'(k);
            logic [5:0]  x = ref_idx(a);
            if (!got_lo && x < 32) begin a_lo = a; i_lo = x; got_lo = 1; end
            if (!got_hi && x >= 32) begin a_hi = a; i_hi = x; got_hi = 1; end
        end
        hash_en = 1;
        hash_lo = 32'(1) << i_lo; hash_hi = '0;
        send_addr(a_lo, 0, 1'b1, "R4 R5 hash hit in low word");
        hash_lo = '0; hash_hi = 32'(1) << i_lo;
        send_addr(a_lo, 0, 1'b0, "R5 same bit in high word misses");
        hash_lo = '0; hash_hi = 32'(1) << (i_hi - 6'd32);
        send_addr(a_hi, 0, 1'b1, "R4 R5 hash hit in high word");
        hash_hi = ~(32'(1) << (i_hi - 6'd32)); hash_lo = '1;
        send_addr(a_hi, 0, 1'b0, "R4 hash miss all other bits set");
        hash_en = 0; hash_lo = '1; hash_hi = '1;
        send_addr(a_lo, 0, 1'b0, "R6 hash disabled rejects");
        hash_lo = '0; hash_hi = '0;
    endtask

    task automatic t_tail_and_gaps();
        send_addr(station_addr, 2, 1'b1, "R10 address with idle gaps");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'hFF;
            @(negedge clk); rx_valid = 1'b0;
            chk("R9 valid held over tail", verdict_valid, 1'b1);
            chk("R10 tail bytes ignored", accept, 1'b1);
        end
        station_addr = 48'h02_00_00_00_00_01;   // mode change after verdict
        @(negedge clk);
        chk("R9 verdict held after settings change", accept, 1'b1);
        send_addr(48'h02_11_22_33_44_55, 1, 1'b0, "R1 new frame re-evaluated");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast_all();
        t_hash();
        t_tail_and_gaps();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule